// File: doc/BRIEF.md
# Two-Channel Event-Action PWM Generator

This block produces two PWM outputs from one shared up-counting time base. The counter runs from zero up to a programmed period and then returns to zero. It advances only in free-run mode, at a rate set by a prescaler followed by a second divider.

Each channel has a compare value and an action word. The action word attaches a 2-bit action (none, low, high or toggle) to three counter events: reaching zero, reaching the period, and matching the channel's compare value while counting up. The output edges therefore come from these programmed actions rather than from a fixed comparison. Inverting a channel's polarity means swapping its high and low actions.

A software force register can hold either output low or high, overriding the action result. A newly written force value takes effect at a selectable reload point.

Everything is programmed through a single write port: address, data and a write strobe. No read path is provided.

Top module: `pwmaq_top`

## Requirements
- R1: The counter starts at 0 after reset. On each advance it increments by one. When the count is greater than or equal to the period register, it moves to 0 instead.
- R2: The counter advances once every (P+1)*(T+1) clock cycles. P is the prescale field, bits 2:0 of control register address 5. T is the divider field, bits 5:3 of the same register.
- R3: When the run bit (bit 6 of address 5) is 0, the counter, both dividers and both action-qualified output levels hold their values.
- R4: Action codes are 0 = no change, 1 = drive low, 2 = drive high and 3 = invert the current level.
- R5: Each action word has three fields: bits 1:0 for the zero event, bits 3:2 for the period event and bits 5:4 for the compare-up event. An event is the counter taking that value on an advance.
- R6: Output pwm_a uses the compare register at address 1 and the action word at address 3. Output pwm_b uses the compare register at address 2 and the action word at address 4. The period register is at address 0.
- R7: When several events coincide on one advance, only the highest-priority event's action is applied, even if that action is 0. Compare-up has the highest priority, then period, then zero.
- R8: With action word 0x1A the output is high for counts 0 to C-1 and for count P, and low for counts C to P-1. Here C is the compare value and P the period, with 0 < C < P. Action word 0x25 gives the complementary waveform.
- R9: The force register at address 6 holds a code for pwm_a in bits 1:0 and for pwm_b in bits 3:2. An applied code of 1 holds the output low and 2 holds it high, whatever the action level. Codes 0 and 3 release the output to its action level.
- R10: Force codes are written into a holding copy. They are applied according to bits 7:6 of the force register: 0 = at the next zero event, 1 = at the next period event, 2 or 3 = on the clock after the write.
- R11: After reset all registers are 0, the counter is stopped, and both outputs are low.
- R12: Writes to addresses 7 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register written per clock |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | PWM channel A |
| pwm_b | output | 1 | PWM channel B |

## Verification
The embedded assertions check the following on every clock:
- the counter wraps to zero after reaching the period;
- the counter and levels freeze while stopped;
- back-to-back advances occur only with the prescaler set to 1:1;
- a compare-up high action wins over coincident events;
- a lone zero-event toggle inverts the level;
- an applied force changes only at its reload point.

Three behaviours only the bench scenarios can show: the exact waveform shape for normal and inverted action words, the total division ratio of the two cascaded dividers, and that force codes override the outputs seen at the pins. A cycle-by-cycle reference model runs alongside the design through directed and random register traffic, including stray writes to unused addresses.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } act_e;

   // one action field per counter event; zero-event field in the low bits
   typedef struct packed {
      logic [1:0] cmp_up;
      logic [1:0] prd;
      logic [1:0] zro;
   } act_word_t;

   localparam int unsigned REG_PERIOD = 0;
   localparam int unsigned REG_CMP_A  = 1;
   localparam int unsigned REG_CMP_B  = 2;
   localparam int unsigned REG_ACT_A  = 3;
   localparam int unsigned REG_ACT_B  = 4;
   localparam int unsigned REG_CTRL   = 5;
   localparam int unsigned REG_FORCE  = 6;

   function automatic logic act_apply(input logic [1:0] code, input logic cur);
      case (code)
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction

endpackage

// File: rtl/pwmaq_regs.sv
module pwmaq_regs
   import pwmaq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 3,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [CNT_W-1:0]       period,
   output logic [1:0][CNT_W-1:0]  cmp,
   output act_word_t [1:0]        act,
   output logic [DIV_W-1:0]       psc,
   output logic [DIV_W-1:0]       tbd,
   output logic                   run,
   output logic [1:0][1:0]        fshadow,
   output logic [1:0]             rsel
);
   localparam int RUN_BIT = 2 * DIV_W;

   generate
      if (DATA_W < CNT_W || DATA_W < 8 || RUN_BIT >= DATA_W) begin : g_bad_width
         $error("pwmaq_regs: DATA_W too narrow for fields");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period  <= '0;
         cmp     <= '0;
         act     <= '0;
         psc     <= '0;
         tbd     <= '0;
         run     <= 1'b0;
         fshadow <= '0;
         rsel    <= '0;
      end else if (wr_en) begin
         case (int'(wr_addr))
            REG_PERIOD: period <= wr_data[CNT_W-1:0];
            REG_CMP_A:  cmp[0] <= wr_data[CNT_W-1:0];
            REG_CMP_B:  cmp[1] <= wr_data[CNT_W-1:0];
            REG_ACT_A:  act[0] <= act_word_t'(wr_data[5:0]);
            REG_ACT_B:  act[1] <= act_word_t'(wr_data[5:0]);
            REG_CTRL: begin
               psc <= wr_data[DIV_W-1:0];
               tbd <= wr_data[2*DIV_W-1:DIV_W];
               run <= wr_data[RUN_BIT];
            end
            REG_FORCE: begin
               fshadow[0] <= wr_data[1:0];
               fshadow[1] <= wr_data[3:2];
               rsel       <= wr_data[7:6];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pwmaq_timebase.sv
module pwmaq_timebase #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] psc,
   input  logic [DIV_W-1:0] tbd,
   input  logic [CNT_W-1:0] period,
   output logic             tick,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             ev_zero,
   output logic             ev_prd
);
   logic [DIV_W-1:0] psc_cnt, tbd_cnt;
   logic [CNT_W-1:0] cnt;
   logic             psc_hit, tbd_hit;

   assign psc_hit = (psc_cnt >= psc);
   assign tbd_hit = (tbd_cnt >= tbd);
   assign tick    = run && psc_hit && tbd_hit;
   assign cnt_nxt = (cnt >= period) ? '0 : cnt + 1'b1;
   assign ev_zero = tick && (cnt_nxt == '0);
   assign ev_prd  = tick && (cnt_nxt == period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_cnt <= '0;
         tbd_cnt <= '0;
         cnt     <= '0;
      end else if (run) begin
         if (psc_hit) begin
            psc_cnt <= '0;
            tbd_cnt <= tbd_hit ? '0 : tbd_cnt + 1'b1;
         end else begin
            psc_cnt <= psc_cnt + 1'b1;
         end
         if (tick) cnt <= cnt_nxt;
      end
   end

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt >= period) |=> (cnt == '0));               // R1
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));                                 // R3
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || psc == '0));                         // R2
endmodule

// File: rtl/pwmaq_channel.sv
module pwmaq_channel
   import pwmaq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             ev_zero,
   input  logic             ev_prd,
   input  logic [CNT_W-1:0] cmp,
   input  act_word_t        act,
   input  logic [1:0]       fshadow,
   input  logic             reload,
   output logic             pwm
);
   logic       ev_cmp, level;
   logic [1:0] sel_act, force_act;

   assign ev_cmp = tick && (cnt_nxt == cmp);

   always_comb begin
      if (ev_cmp)       sel_act = act.cmp_up;
      else if (ev_prd)  sel_act = act.prd;
      else if (ev_zero) sel_act = act.zro;
      else              sel_act = ACT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level     <= 1'b0;
         force_act <= '0;
      end else begin
         if (tick)   level     <= act_apply(sel_act, level);
         if (reload) force_act <= fshadow;
      end
   end

   always_comb begin
      case (force_act)
         ACT_LOW:  pwm = 1'b0;
         ACT_HIGH: pwm = 1'b1;
         default:  pwm = level;
      endcase
   end

   AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(level));                              // R3
   AST_CMP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_cmp && act.cmp_up == ACT_HIGH) |=> level);          // R7
   AST_ZERO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_zero && !ev_prd && !ev_cmp && act.zro == ACT_TOGGLE)
      |=> (level != $past(level)));                           // R4
   AST_FORCE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(force_act));                        // R10
endmodule

// File: rtl/pwmaq_top.sv
module pwmaq_top
   import pwmaq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 3,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_a,
   output logic              pwm_b
);
   localparam int NCH = 2;

   generate
      if (CNT_W < 2 || DIV_W < 1) begin : g_bad_param
         $error("pwmaq_top: CNT_W and DIV_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0]          period, cnt_nxt;
   logic [NCH-1:0][CNT_W-1:0] cmp;
   act_word_t [NCH-1:0]       act;
   logic [DIV_W-1:0]          psc, tbd;
   logic                      run, tick, ev_zero, ev_prd, reload;
   logic [NCH-1:0][1:0]       fshadow;
   logic [1:0]                rsel;
   logic [NCH-1:0]            pwm_vec;

   pwmaq_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .period(period), .cmp(cmp), .act(act), .psc(psc), .tbd(tbd), .run(run),
      .fshadow(fshadow), .rsel(rsel));

   pwmaq_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(run), .psc(psc), .tbd(tbd), .period(period),
      .tick(tick), .cnt_nxt(cnt_nxt), .ev_zero(ev_zero), .ev_prd(ev_prd));

   always_comb begin
      case (rsel)
         2'd0:    reload = ev_zero;
         2'd1:    reload = ev_prd;
         default: reload = 1'b1;
      endcase
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwmaq_channel #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_nxt(cnt_nxt),
         .ev_zero(ev_zero), .ev_prd(ev_prd), .cmp(cmp[i]), .act(act[i]),
         .fshadow(fshadow[i]), .reload(reload), .pwm(pwm_vec[i]));
   end

   assign pwm_a = pwm_vec[0];
   assign pwm_b = pwm_vec[1];
endmodule

// File: tb/tb_pwmaq_top.sv
`timescale 1ns/1ps
module tb_pwmaq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        pwm_a, pwm_b;

   int n_chk = 0, n_err = 0;
   bit chk_en = 1'b0;
   string cur_req = "R11";

   always #2.5 clk = ~clk;

   pwmaq_top dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b));

   // reference model state
   int m_prd, m_psc, m_tbd, m_rsel, m_pc, m_tc, m_cnt;
   bit m_run;
   int m_cmp[2], m_act[2], m_fsh[2], m_fa[2];
   bit m_lvl[2];

   function automatic bit act_fn(int code, bit cur);
      if (code == 1) return 1'b0;
      if (code == 2) return 1'b1;
      if (code == 3) return !cur;
      return cur;
   endfunction

   function automatic bit exp_out(int c);
      if (m_fa[c] == 1) return 1'b0;
      if (m_fa[c] == 2) return 1'b1;
      return m_lvl[c];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prd <= 0; m_psc <= 0; m_tbd <= 0; m_rsel <= 0; m_run <= 0;
         m_pc <= 0; m_tc <= 0; m_cnt <= 0;
         for (int c = 0; c < 2; c++) begin
            m_cmp[c] <= 0; m_act[c] <= 0; m_fsh[c] <= 0; m_fa[c] <= 0; m_lvl[c] <= 0;
         end
      end else begin
         bit tk, z, p, rl;
         int nx;
         tk = m_run && (m_pc >= m_psc) && (m_tc >= m_tbd);
         if (m_run) begin
            if (m_pc >= m_psc) begin
               m_pc <= 0;
               m_tc <= (m_tc >= m_tbd) ? 0 : m_tc + 1;
            end else m_pc <= m_pc + 1;
         end
         nx = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
         z = tk && (nx == 0);
         p = tk && (nx == m_prd);
         if (tk) begin
            m_cnt <= nx;
            for (int c = 0; c < 2; c++) begin
               int a;
               if (nx == m_cmp[c]) a = (m_act[c] >> 4) & 3;
               else if (p)         a = (m_act[c] >> 2) & 3;
               else if (z)         a = m_act[c] & 3;
               else                a = 0;
               m_lvl[c] <= act_fn(a, m_lvl[c]);
            end
         end
         rl = (m_rsel == 0) ? z : (m_rsel == 1) ? p : 1'b1;
         if (rl) begin m_fa[0] <= m_fsh[0]; m_fa[1] <= m_fsh[1]; end
         if (wr_en) begin
            case (wr_addr)
               4'd0: m_prd <= wr_data;
               4'd1: m_cmp[0] <= wr_data;
               4'd2: m_cmp[1] <= wr_data;
               4'd3: m_act[0] <= wr_data & 16'h3F;
               4'd4: m_act[1] <= wr_data & 16'h3F;
               4'd5: begin
                  m_psc <= wr_data & 7; m_tbd <= (wr_data >> 3) & 7; m_run <= wr_data[6];
               end
               4'd6: begin
                  m_fsh[0] <= wr_data & 3; m_fsh[1] <= (wr_data >> 2) & 3;
                  m_rsel <= (wr_data >> 6) & 3;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, int act_v, int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (chk_en) begin
         check({cur_req, " pwm_a"}, pwm_a, exp_out(0));
         check({cur_req, " pwm_b"}, pwm_b, exp_out(1));
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int edges;
      bit prev, held;
      void'($urandom(32'h1357));
      idle(3);
      check("R11 pwm_a reset", pwm_a, 0);
      check("R11 pwm_b reset", pwm_b, 0);
      rst_n = 1'b1;
      idle(4);
      check("R11 stopped output", pwm_a | pwm_b, 0);
      chk_en = 1'b1;

      // R8 normal on A, inverted on B, shared compare value (R6)
      cur_req = "R8";
      wr(0, 9); wr(1, 4); wr(2, 4); wr(3, 'h1A); wr(4, 'h25); wr(5, 'h40);
      idle(25);
      check("R8 complementary", pwm_a, !pwm_b);
      idle(20);

      // R6 distinct compare values per channel
      cur_req = "R6";
      wr(2, 7); wr(4, 'h1A);
      idle(40);

      // R2 cascaded divider: P=2, T=1 -> 6 clocks per advance, period 3 -> toggle every 24
      cur_req = "R2";
      wr(5, 'h00); wr(0, 3); wr(3, 'h03); wr(1, 100); wr(5, 'h4A);
      idle(30);
      edges = 0; prev = pwm_a;
      for (int k = 0; k < 96; k++) begin
         @(negedge clk);
         if (pwm_a != prev) edges++;
         prev = pwm_a;
      end
      check("R2 toggles in 96 clocks", edges, 4);

      // R3 stop freezes outputs
      cur_req = "R3";
      wr(5, 'h0A);
      held = pwm_a;
      idle(30);
      check("R3 frozen pwm_a", pwm_a, held);

      // R7 priority: compare equals period (A), compare equals zero (B)
      cur_req = "R7";
      wr(0, 5); wr(1, 5); wr(3, 'h18); wr(2, 0); wr(4, 'h12); wr(5, 'h40);
      idle(20);
      check("R7 cmp beats period", pwm_a, 0);
      check("R7 cmp beats zero", pwm_b, 0);

      // R9/R10 force: immediate reload on B high, zero reload on A high
      cur_req = "R10";
      wr(6, 'h88);
      idle(2);
      check("R9 force B high", pwm_b, 1);
      wr(6, 'h02);
      idle(10);
      check("R9 force A high at zero", pwm_a, 1);
      cur_req = "R9";
      wr(6, 'h40);
      idle(20);
      wr(6, 'h80);
      idle(10);

      // R12 writes to unused addresses
      cur_req = "R12";
      for (int k = 0; k < 40; k++) wr(7 + ($urandom % 9), $urandom);
      idle(10);

      // R4 R5 constrained random traffic
      cur_req = "R4 R5 random";
      for (int k = 0; k < 600; k++) begin
         int a;
         a = $urandom % 8;
         case (a)
            0: wr(0, $urandom_range(0, 12));
            1, 2: wr(a, $urandom_range(0, 13));
            3, 4: wr(a, $urandom % 64);
            5: wr(5, $urandom_range(0, 2) | ($urandom_range(0, 1) << 3)
                     | ((($urandom % 8) != 0) << 6));
            6: wr(6, $urandom % 256);
            default: wr(7 + ($urandom % 9), $urandom);
         endcase
         idle($urandom_range(0, 6));
      end
      chk_en = 1'b0;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule